// File: doc/BRIEF.md
# Watchdog Timer with Guarded Status Register

This block is a free-running watchdog. A prescaler divides the system clock by a fixed factor (8192 by default) and each prescaler tick advances an 8-bit up-counter. Software has to rewrite the counter often enough that it never wraps. If the counter does roll over from all-ones to zero, the block raises a one-cycle internal reset pulse for the rest of the chip. It also sets a sticky flag so that software can tell, after the restart, that the watchdog caused it.

Software reaches the block through a small register bus with an address, a write strobe, write data and combinational read data. Address 0 is the guarded control/status register and address 1 is the counter. The status flag and the write-enable (unlock) bit each have an inhibit companion bit that sits next to them. A write changes the guarded bit only when that same write puts 0 in the companion. The flag survives the internal reset it causes. Only the external reset pin or a deliberate, unlocked software write clears it.

Control/status register layout (address 0): bit 0 is the watchdog-reset flag, bit 1 is the flag's inhibit bit, bit 2 is the unlock bit, bit 3 is the unlock's inhibit bit, and bits 7:4 read 0.

Top module: `wdg_guard_top`

## Requirements
- R1: While the external reset `rst_n` is low, the counter reads 0x00, the control/status register reads 0x0A (flag 0, unlock 0, both inhibit bits 1) and `int_rst_o` is 0.
- R2: The counter (read at address 1) increases by exactly one every DIV clock cycles, and `int_rst_o` stays 0 while the counter has not wrapped.
- R3: A write to address 1 loads the counter with `wdata` on that clock edge and restarts the prescaler, so the next increment comes DIV cycles after the write edge.
- R4: If a counter write falls in the same cycle as a prescaler tick, the written value is loaded and that tick causes no increment.
- R5: A tick while the counter holds 0xFF makes the counter 0x00, sets the flag (bit 0 of address 0) on the same edge, and drives `int_rst_o` high for exactly one cycle right after that edge.
- R6: While `int_rst_o` is high, the counter and prescaler are held at zero and a counter write is ignored. The next increment therefore comes DIV+1 cycles after the wrap edge. The flag is not cleared by the pulse.
- R7: Bits 1 and 3 of address 0 always read back as 1, whatever is written to them, and bits 7:4 read 0.
- R8: The unlock bit (bit 2) takes the value of `wdata[2]` only on a write to address 0 with `wdata[3]` = 0. Otherwise it keeps its value.
- R9: The flag is cleared only by a write to address 0 made while the unlock bit is already 1 (before that write) that carries `wdata[1]` = 0 and `wdata[0]` = 0. No software write ever sets the flag.
- R10: If a clearing write and a counter wrap fall in the same cycle, the flag ends up set.
- R11: Asserting `rst_n` clears the flag, the unlock bit and the counter at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous assert |
| addr | input | 1 | Register select: 0 control/status, 1 counter |
| wr | input | 1 | Write strobe, one write per cycle it is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| int_rst_o | output | 1 | One-cycle internal reset pulse on counter wrap |

## Verification
The counter is loaded with every start value from 0x00 to 0xFD and then read on every cycle for two prescaler periods. This shows whether the divide ratio is right for any count, and whether a load truly restarts the prescaler rather than letting it run on. A load placed exactly on a tick tells apart a design where the CPU wins from one where the tick also lands. Loading 0xFE and watching the output through the wrap shows the pulse width and timing, and the extra cycle the pulse holds the counter. The guarded register is driven with a sequence of writes that vary one companion bit at a time, with the unlock bit first clear and then set, to show which write can change which bit. A clear placed on the wrap edge settles the priority between the two.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // register select on the bus
  typedef enum logic {
    REG_CSR = 1'b0,
    REG_CNT = 1'b1
  } wdg_reg_e;

  // bit positions inside the control/status register
  localparam int unsigned CSR_FLAG     = 0;
  localparam int unsigned CSR_FLAG_INH = 1;
  localparam int unsigned CSR_UNLK     = 2;
  localparam int unsigned CSR_UNLK_INH = 3;
  localparam int unsigned CSR_USED     = 4;

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_pin_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_pin_ni) begin
    if (!rst_pin_ni) sync_q <= '0;
    else             sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned DIV = 8192
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);

  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] div_d;

  assign tick_o = (div_q == LAST) && !clr_i;

  always_comb begin
    div_d = div_q;
    if (clr_i)       div_d = '0;
    else if (tick_o) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // R2: a tick is never followed by another tick on the next cycle
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         hold_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = hold_i || ld_i || tick_i;
  assign wrap_o = tick_i && !ld_i && !hold_i && (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i)      cnt_d = '0;
    else if (ld_i)   cnt_d = ld_val_i;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: without a load or hold the count only stays or steps by one
  a_r2_step_only: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_i && !hold_i) |=> (cnt_q == $past(cnt_q) || cnt_q == W'($past(cnt_q) + 1'b1)));

  // R3: a load that is not overridden lands on the next edge
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_i && !hold_i) |=> cnt_q == $past(ld_val_i));

endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [CSR_USED-1:0] wbits_i,
  input  logic                set_i,
  output logic [CSR_USED-1:0] csr_o,
  output logic                flag_o
);

  logic flag_q, flag_d;
  logic unlk_q, unlk_d;
  logic clr_req;

  assign clr_req = wr_i && unlk_q && !wbits_i[CSR_FLAG_INH] && !wbits_i[CSR_FLAG];

  always_comb begin
    unlk_d = unlk_q;
    if (wr_i && !wbits_i[CSR_UNLK_INH]) unlk_d = wbits_i[CSR_UNLK];
    flag_d = flag_q;
    if (clr_req) flag_d = 1'b0;
    if (set_i)   flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      unlk_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      unlk_q <= unlk_d;
    end
  end

  always_comb begin
    csr_o               = '0;
    csr_o[CSR_FLAG]     = flag_q;
    csr_o[CSR_FLAG_INH] = 1'b1;
    csr_o[CSR_UNLK]     = unlk_q;
    csr_o[CSR_UNLK_INH] = 1'b1;
  end

  assign flag_o = flag_q;

  // R8: unlock moves only on a write whose companion bit is 0
  a_r8_unlock_guard: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_i && !wbits_i[CSR_UNLK_INH]) |=> $stable(unlk_q));

  // R9: a locked register never loses the flag
  a_r9_flag_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !unlk_q) |=> flag_q);

  // R10: a set request always leaves the flag high
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> flag_q);

endmodule

// File: rtl/wdg_guard_top.sv
module wdg_guard_top
  import wdg_pkg::*;
#(
  parameter int unsigned DIV    = 8192,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              int_rst_o
);

  logic             rst_ni;
  logic             tick;
  logic             cnt_wr;
  logic             csr_wr;
  logic             wrap;
  logic             pulse_q;
  logic             flag;
  logic [CNT_W-1:0] cnt;
  logic [CSR_USED-1:0] csr;

  assign cnt_wr = wr && (wdg_reg_e'(addr) == REG_CNT);
  assign csr_wr = wr && (wdg_reg_e'(addr) == REG_CSR);

  wdg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_pin_ni (rst_n),
    .rst_no     (rst_ni)
  );

  wdg_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr_i  (cnt_wr || pulse_q),
    .tick_o (tick)
  );

  wdg_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ld_i     (cnt_wr),
    .ld_val_i (wdata[CNT_W-1:0]),
    .hold_i   (pulse_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  wdg_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_i    (csr_wr),
    .wbits_i (wdata[CSR_USED-1:0]),
    .set_i   (wrap),
    .csr_o   (csr),
    .flag_o  (flag)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wrap;
  end

  assign int_rst_o = pulse_q;

  always_comb begin
    if (wdg_reg_e'(addr) == REG_CNT) rdata = DATA_W'(cnt);
    else                             rdata = DATA_W'(csr);
  end

  // R5: the internal reset lasts exactly one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_ni)
    int_rst_o |=> !int_rst_o);

  // R5: the flag is already up while the pulse is out
  a_r5_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    int_rst_o |-> flag);

  // R6: the counter reads zero during and right after the pulse
  a_r6_cnt_held: assert property (@(posedge clk) disable iff (!rst_ni)
    int_rst_o |-> (cnt == '0) ##1 (cnt == '0));

  // R6: the pulse does not touch the flag
  a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_ni)
    int_rst_o |=> flag);

endmodule

// File: tb/test_wdg_guard_top.sv
module test_wdg_guard_top;

  localparam int P = 4;

  logic       clk;
  logic       rst_n;
  logic       addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       int_rst_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wdg_guard_top #(.DIV(P), .CNT_W(8), .DATA_W(8)) i_wdg_guard_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr        (wr),
    .wdata     (wdata),
    .rdata     (rdata),
    .int_rst_o (int_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // write on the next edge; returns at the negedge just after it
  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_csr(input string tag, input logic [7:0] exp);
    addr = 1'b0; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic rd_cnt(input string tag, input logic [7:0] exp);
    addr = 1'b1; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 1'b0; wr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_csr("R1 csr", 8'h0A);
    rd_cnt("R1 cnt", 8'h00);
    chk("R1 pulse", {7'd0, int_rst_o}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R3 sweep of start values
    for (int v = 0; v < 254; v++) begin
      bus_wr(1'b1, 8'(v));
      for (int k = 0; k <= 2 * P; k++) begin
        #1;
        chk("R2/R3 count", rdata, 8'(v + k / P));
        chk("R2 no pulse", {7'd0, int_rst_o}, 8'h00);
        @(negedge clk);
      end
    end

    // R4 write on a tick cycle
    bus_wr(1'b1, 8'h40);
    repeat (P - 1) @(negedge clk);
    wdata = 8'h10; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    for (int k = 0; k <= P; k++) begin
      #1;
      chk("R4 cpu wins", rdata, (k < P) ? 8'h10 : 8'h11);
      @(negedge clk);
    end

    // R5/R6 wrap
    bus_wr(1'b1, 8'hFE);
    for (int k = 0; k <= 3 * P + 2; k++) begin
      logic [7:0] e;
      if (k < P)              e = 8'hFE;
      else if (k < 2 * P)     e = 8'hFF;
      else if (k < 3 * P + 1) e = 8'h00;
      else                    e = 8'h01;
      #1;
      chk("R5/R6 count", rdata, e);
      chk("R5 pulse", {7'd0, int_rst_o}, (k == 2 * P) ? 8'h01 : 8'h00);
      if (k == 2 * P) begin
        // R6 a counter write during the pulse is dropped
        wdata = 8'h77; wr = 1'b1;
      end else begin
        wr = 1'b0;
      end
      @(negedge clk);
    end
    rd_csr("R6 flag kept", 8'h0B);

    // R7/R8/R9 guarded writes
    bus_wr(1'b0, 8'h00); rd_csr("R9 locked clear", 8'h0B);
    bus_wr(1'b0, 8'h0C); rd_csr("R8 inhibited unlock", 8'h0B);
    bus_wr(1'b0, 8'h04); rd_csr("R8/R9 unlock, old lock", 8'h0F);
    bus_wr(1'b0, 8'h06); rd_csr("R9 flag inhibited", 8'h0F);
    bus_wr(1'b0, 8'h05); rd_csr("R9 write one", 8'h0F);
    bus_wr(1'b0, 8'h04); rd_csr("R9 cleared", 8'h0E);
    bus_wr(1'b0, 8'hFF); rd_csr("R7 inhibit bits", 8'h0E);
    bus_wr(1'b0, 8'h01); rd_csr("R8/R9 relock no set", 8'h0A);
    bus_wr(1'b0, 8'h04); rd_csr("R8 unlock", 8'h0E);

    // R10 clear on the wrap edge
    bus_wr(1'b1, 8'hFE);
    repeat (2 * P - 1) @(negedge clk);
    addr = 1'b0; wdata = 8'h04; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    #1;
    chk("R10 pulse", {7'd0, int_rst_o}, 8'h01);
    chk("R10 set wins", rdata, 8'h0F);

    // R11 pin reset clears flag at once
    @(negedge clk);
    rst_n = 1'b0;
    rd_csr("R11 csr", 8'h0A);
    rd_cnt("R11 cnt", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule